// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge Interrupts

This block is a sixteen-line general-purpose I/O port controlled through a byte-wide register interface. It is meant to sit behind a serial-bus slave that turns bus transactions into single-cycle byte writes and combinational byte reads. Every line has its own bits for direction, output value, open-drain drive, pull-up and pull-down enables, interrupt mask and a two-bit edge selector. The pin side gives one output value, one output enable and one enable for each pad feature per line. The pad cells themselves are outside the block.

Each pin input passes through a two-stage synchronizer. After that, an edge detector compares the current synchronized level with the one from the previous cycle. When an unmasked line sees the edge its selector picks, a sticky source bit is set. The active-low interrupt output stays asserted while any source bit is set. Software clears a source bit by writing a one to it. A keyed pair of writes to one address returns every register to its reset value.

Every 16-bit register takes two consecutive byte addresses, and the lower address holds bits 15..8. The edge selectors take four consecutive addresses. Lines 15..12 are at the first of these, and within each byte the lines run in descending order with two bits per line.

Top module: `gpx_port`

## Requirements
- R1: After reset, the direction and interrupt-mask registers read 0xFF at all four of their byte addresses. Pull-up, pull-down, open-drain, output latch, edge selector and source bits read 0x00, and irq_n is high.
- R2: Each 16-bit register holds bits 15..8 at its lower (even) address and bits 7..0 at the following address. Pull-up is at 0x06, pull-down at 0x08, open-drain at 0x0A, direction at 0x0E, data at 0x10, mask at 0x12 and source at 0x18.
- R3: A direction bit of 1 makes the line an input, and its pin_oe bit is 0. A direction bit of 0 makes the line an output driving its output-latch bit on pin_out. Reads of the data address return the synchronized pin level for input lines and the latch bit for output lines.
- R4: When an output line has its open-drain bit set, pin_oe is asserted only while the latch bit is 0. A latch bit of 1 releases the line.
- R5: pin_pu, pin_pd and pin_od mirror the pull-up, pull-down and open-drain registers bit for bit.
- R6: Each line has a two-bit edge selector at bits 2n+1:2n of the 32-bit field at 0x14..0x17, with 0x14 holding bits 31..24. Code 01 selects rising edges, 10 falling, 11 both and 00 none. An edge that the code does not select sets nothing.
- R7: A line whose mask bit is 1 never sets its source bit.
- R8: A source bit, once set, holds until a 1 is written to it. Writing 0 leaves it set.
- R9: irq_n is low exactly while at least one source bit is set.
- R10: Writing 0x12 and then 0x34 to address 0x7D, with no other write in between, restores every register to its R1 value.
- R11: Any write other than 0x34 to 0x7D, following a write of 0x12 there, abandons the key. A later 0x34 then has no effect. Address 0x7D always reads 0x00.
- R12: Suppose a pin changes just after clock edge E0. Its source bit and irq_n then change at edge E3. They still hold their old value after edge E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte address for reads and writes |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; rd_data is 0 when low |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Output value per line |
| pin_oe | output | 16 | Output enable per line |
| pin_od | output | 16 | Open-drain select per line |
| pin_pu | output | 16 | Pull-up enable per line |
| pin_pd | output | 16 | Pull-down enable per line |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check four properties on every cycle. No input line ever has its driver enabled. No open-drain line drives a high level. A masked line never gains a source bit, and source bits stay set unless a write to the source or key address comes first. A back-to-back key pair also restores the reset values. Some behaviour only the bench scenarios can show: the byte placement of each field, the meaning of each edge-selector code, read-back of pin levels against latch values, the exact three-edge latency from pin to irq_n, and abandoning the key after an intervening write.

// File: rtl/gpx_pkg.sv
// Shared address map and constants for the GPIO port.
// Assumes a 16-line port: every 16-bit register takes two byte addresses.
package gpx_pkg;
    localparam int unsigned NLINES = 16;
    localparam int unsigned AW     = 8;
    localparam int unsigned DW     = 8;

    localparam logic [AW-1:0] A_PU_H   = 8'h06;
    localparam logic [AW-1:0] A_PU_L   = 8'h07;
    localparam logic [AW-1:0] A_PD_H   = 8'h08;
    localparam logic [AW-1:0] A_PD_L   = 8'h09;
    localparam logic [AW-1:0] A_OD_H   = 8'h0A;
    localparam logic [AW-1:0] A_OD_L   = 8'h0B;
    localparam logic [AW-1:0] A_DIR_H  = 8'h0E;
    localparam logic [AW-1:0] A_DIR_L  = 8'h0F;
    localparam logic [AW-1:0] A_DAT_H  = 8'h10;
    localparam logic [AW-1:0] A_DAT_L  = 8'h11;
    localparam logic [AW-1:0] A_MSK_H  = 8'h12;
    localparam logic [AW-1:0] A_MSK_L  = 8'h13;
    localparam logic [AW-1:0] A_SNS_0  = 8'h14;
    localparam logic [AW-1:0] A_SNS_1  = 8'h15;
    localparam logic [AW-1:0] A_SNS_2  = 8'h16;
    localparam logic [AW-1:0] A_SNS_3  = 8'h17;
    localparam logic [AW-1:0] A_SRC_H  = 8'h18;
    localparam logic [AW-1:0] A_SRC_L  = 8'h19;
    localparam logic [AW-1:0] A_KEY    = 8'h7D;

    localparam logic [DW-1:0] KEY_FIRST  = 8'h12;
    localparam logic [DW-1:0] KEY_SECOND = 8'h34;
endpackage

// File: rtl/gpx_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; STAGES >= 2.
module gpx_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: shift the level one stage further into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
// Configuration register file and keyed software reset for the GPIO port.
// Assumes NL == 16 so the fixed byte map in gpx_pkg applies. Source bits
// live in gpx_edge; this block only decodes their write-one-to-clear mask.
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned NL = NLINES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_en,
    output logic [NL-1:0]   pu_q,
    output logic [NL-1:0]   pd_q,
    output logic [NL-1:0]   od_q,
    output logic [NL-1:0]   dir_q,
    output logic [NL-1:0]   dout_q,
    output logic [NL-1:0]   mask_q,
    output logic [2*NL-1:0] sense_q,
    output logic [NL-1:0]   src_clr,
    output logic            key_hit
);
    logic armed_q;

    // Purpose: recognise the completing second byte of the reset key.
    always_comb key_hit = wr_en && armed_q && (addr == A_KEY) && (wr_data == KEY_SECOND);

    // Purpose: decode a write-one-to-clear mask for the source bits.
    always_comb begin
        src_clr = '0;
        if (wr_en && addr == A_SRC_H) src_clr[15:8] = wr_data;
        if (wr_en && addr == A_SRC_L) src_clr[7:0]  = wr_data;
    end

    // Purpose: track whether the first key byte was the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (wr_en) armed_q <= (addr == A_KEY) && (wr_data == KEY_FIRST);
    end

    // Purpose: hold the per-line configuration; the key restores defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || key_hit) begin
            pu_q    <= '0;
            pd_q    <= '0;
            od_q    <= '0;
            dir_q   <= '1;
            dout_q  <= '0;
            mask_q  <= '1;
            sense_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PU_H:  pu_q[15:8]      <= wr_data;
                A_PU_L:  pu_q[7:0]       <= wr_data;
                A_PD_H:  pd_q[15:8]      <= wr_data;
                A_PD_L:  pd_q[7:0]       <= wr_data;
                A_OD_H:  od_q[15:8]      <= wr_data;
                A_OD_L:  od_q[7:0]       <= wr_data;
                A_DIR_H: dir_q[15:8]     <= wr_data;
                A_DIR_L: dir_q[7:0]      <= wr_data;
                A_DAT_H: dout_q[15:8]    <= wr_data;
                A_DAT_L: dout_q[7:0]     <= wr_data;
                A_MSK_H: mask_q[15:8]    <= wr_data;
                A_MSK_L: mask_q[7:0]     <= wr_data;
                A_SNS_0: sense_q[31:24]  <= wr_data;
                A_SNS_1: sense_q[23:16]  <= wr_data;
                A_SNS_2: sense_q[15:8]   <= wr_data;
                A_SNS_3: sense_q[7:0]    <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpx_edge.sv
// Edge detection and sticky interrupt sources, one slice per line.
// Assumes lvl is already synchronized. Selector bit 2n picks rising and
// bit 2n+1 falling edges. A new edge wins over a clear in the same cycle;
// the key reset wins over both.
module gpx_edge #(
    parameter int unsigned NL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   lvl,
    input  logic [NL-1:0]   mask,
    input  logic [2*NL-1:0] sense,
    input  logic [NL-1:0]   clr,
    input  logic            soft_clr,
    output logic [NL-1:0]   src_q
);
    logic [NL-1:0] prev_q;
    logic [NL-1:0] hit;

    for (genvar n = 0; n < NL; n++) begin : g_line
        // Purpose: flag a selected edge on an unmasked line.
        always_comb hit[n] = !mask[n] &&
                             ((sense[2*n]   &&  lvl[n] && !prev_q[n]) ||
                              (sense[2*n+1] && !lvl[n] &&  prev_q[n]));
    end

    // Purpose: remember last cycle's synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Purpose: latch hits until software writes ones to clear them.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) src_q <= '0;
        else                    src_q <= (src_q & ~clr) | hit;
    end
endmodule

// File: rtl/gpx_port.sv
// Top of the sixteen-line GPIO port: register file, synchronizer, edge
// logic, read multiplexer and pin drive. Assumes the host presents one
// byte access per cycle and samples rd_data in the cycle of rd_en.
module gpx_port
    import gpx_pkg::*;
#(
    parameter int unsigned NL        = NLINES,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    addr,
    input  logic [7:0]    wr_data,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic [15:0]   pin_in,
    output logic [15:0]   pin_out,
    output logic [15:0]   pin_oe,
    output logic [15:0]   pin_od,
    output logic [15:0]   pin_pu,
    output logic [15:0]   pin_pd,
    output logic          irq_n
);
    logic [NL-1:0]   pu_q, pd_q, od_q, dir_q, dout_q, mask_q, src_q, src_clr, lvl;
    logic [2*NL-1:0] sense_q;
    logic [NL-1:0]   data_view;
    logic            key_hit;

    gpx_regs #(.NL(NL)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .pu_q(pu_q), .pd_q(pd_q), .od_q(od_q), .dir_q(dir_q), .dout_q(dout_q),
        .mask_q(mask_q), .sense_q(sense_q), .src_clr(src_clr), .key_hit(key_hit)
    );

    gpx_sync #(.W(NL), .STAGES(SYNC_DEPTH)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    gpx_edge #(.NL(NL)) i_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .mask(mask_q), .sense(sense_q),
        .clr(src_clr), .soft_clr(key_hit), .src_q(src_q)
    );

    // Purpose: data reads show pin level for inputs, latch for outputs.
    always_comb data_view = (dir_q & lvl) | (~dir_q & dout_q);

    // Purpose: select the addressed byte; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_PU_H:  rd_data = pu_q[15:8];
                A_PU_L:  rd_data = pu_q[7:0];
                A_PD_H:  rd_data = pd_q[15:8];
                A_PD_L:  rd_data = pd_q[7:0];
                A_OD_H:  rd_data = od_q[15:8];
                A_OD_L:  rd_data = od_q[7:0];
                A_DIR_H: rd_data = dir_q[15:8];
                A_DIR_L: rd_data = dir_q[7:0];
                A_DAT_H: rd_data = data_view[15:8];
                A_DAT_L: rd_data = data_view[7:0];
                A_MSK_H: rd_data = mask_q[15:8];
                A_MSK_L: rd_data = mask_q[7:0];
                A_SNS_0: rd_data = sense_q[31:24];
                A_SNS_1: rd_data = sense_q[23:16];
                A_SNS_2: rd_data = sense_q[15:8];
                A_SNS_3: rd_data = sense_q[7:0];
                A_SRC_H: rd_data = src_q[15:8];
                A_SRC_L: rd_data = src_q[7:0];
                default: rd_data = '0;
            endcase
        end
    end

    // Purpose: drive pads; open-drain outputs release when the latch is 1.
    always_comb begin
        pin_out = dout_q;
        pin_oe  = ~dir_q & (~od_q | ~dout_q);
        pin_od  = od_q;
        pin_pu  = pu_q;
        pin_pd  = pd_q;
        irq_n   = ~|src_q;
    end
endmodule

// File: rtl/gpx_port_chk.sv
// Checker for gpx_port: cycle-by-cycle properties on pin drive, interrupt
// sources and the keyed reset. Assumes the package address map.
module gpx_port_chk
    import gpx_pkg::*;
#(
    parameter int unsigned NL = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    addr,
    input logic [7:0]    wr_data,
    input logic          wr_en,
    input logic [15:0]   pin_out,
    input logic [15:0]   pin_oe,
    input logic [15:0]   pin_od,
    input logic [NL-1:0] dir_q,
    input logic [NL-1:0] mask_q,
    input logic [NL-1:0] src_q
);
    // R3: an input line never has its driver enabled.
    a_r3_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R4: an open-drain line never drives a high level.
    a_r4_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_od & pin_out) == '0);

    // R7: a masked line never gains a source bit.
    a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_q & ~$past(src_q) & $past(mask_q)) == '0));

    // R8: without a write to the source or key address, set bits stay set.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_SRC_H || addr == A_SRC_L || addr == A_KEY))
        |=> ((src_q & $past(src_q)) == $past(src_q)));

    // R10: a back-to-back key pair restores mask, direction and sources.
    a_r10_key_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wr_data == KEY_SECOND &&
         $past(wr_en && addr == A_KEY && wr_data == KEY_FIRST))
        |=> (mask_q == '1 && dir_q == '1 && src_q == '0));
endmodule

bind gpx_port gpx_port_chk #(.NL(NL)) i_gpx_port_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
    .dir_q(dir_q), .mask_q(mask_q), .src_q(src_q)
);

// File: tb/test_gpx_port.sv
// Scoreboard bench for gpx_port: read tasks queue expected bytes and a
// negedge monitor pops and compares them against rd_data.
module test_gpx_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;
    logic        irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    gpx_port i_gpx_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd),
        .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver tasks start and end one time unit after a rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare each read against the queued expectation.
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard underflow actual=%0h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(8'h0E, 8'hFF, "R1 dir hi");
        rd(8'h0F, 8'hFF, "R1 dir lo");
        rd(8'h12, 8'hFF, "R1 mask hi");
        rd(8'h13, 8'hFF, "R1 mask lo");
        rd(8'h06, 8'h00, "R1 pull-up");
        rd(8'h18, 8'h00, "R1 src hi");
        chk("R1 irq_n", {31'h0, irq_n}, 32'h1);

        // R2 byte order; R3 direction and read-back
        wr(8'h0F, 8'h0F);
        wr(8'h11, 8'hA5);
        wr(8'h0E, 8'h00);
        wr(8'h10, 8'h3C);
        rd(8'h10, 8'h3C, "R2 data hi byte");
        chk("R2 pin_out", {16'h0, pin_out}, 32'h3CA5);
        chk("R3 pin_oe", {16'h0, pin_oe}, 32'hFFF0);
        wr(8'h0E, 8'hFF);
        pin_in = 16'h0006;
        idle(5);
        rd(8'h11, 8'hA6, "R3 data mix of latch and pins");
        rd(8'h10, 8'h00, "R3 input pins read level");

        // R4 open drain, R5 pad enables
        wr(8'h0B, 8'hF0);
        chk("R4 od oe", {16'h0, pin_oe}, 32'h0050);
        chk("R5 pin_od", {16'h0, pin_od}, 32'h00F0);
        wr(8'h06, 8'h81);
        wr(8'h09, 8'h42);
        chk("R5 pin_pu", {16'h0, pin_pu}, 32'h8100);
        chk("R5 pin_pd", {16'h0, pin_pd}, 32'h0042);

        // Edge setup: line0 rise, line1 fall, line2 both, line3 rise (masked), line15 rise
        pin_in = 16'h0000;
        idle(5);
        wr(8'h17, 8'h79);
        wr(8'h14, 8'h40);
        rd(8'h17, 8'h79, "R6 selector byte");
        wr(8'h13, 8'hF8);
        wr(8'h12, 8'h7F);
        pin_in[3] = 1'b1;
        idle(5);
        rd(8'h19, 8'h00, "R7 masked line");
        chk("R7 irq_n", {31'h0, irq_n}, 32'h1);
        pin_in[0] = 1'b1;
        idle(5);
        rd(8'h19, 8'h01, "R6 rising line0");
        chk("R9 irq_n low", {31'h0, irq_n}, 32'h0);
        wr(8'h19, 8'h01);
        chk("R8 clear by one", {31'h0, irq_n}, 32'h1);

        // R12 latency on line 15
        pin_in[15] = 1'b1;
        idle(2);
        chk("R12 not yet at E2", {31'h0, irq_n}, 32'h1);
        idle(1);
        chk("R12 set at E3", {31'h0, irq_n}, 32'h0);
        rd(8'h18, 8'h80, "R6 line15 in high byte");
        wr(8'h18, 8'h00);
        rd(8'h18, 8'h80, "R8 write zero keeps");
        wr(8'h18, 8'h80);
        rd(8'h18, 8'h00, "R8 cleared");
        chk("R9 irq_n high", {31'h0, irq_n}, 32'h1);

        // R6 falling only, both edges, unselected edge
        pin_in[1] = 1'b1;
        idle(5);
        rd(8'h19, 8'h00, "R6 rise ignored on fall line");
        pin_in[1] = 1'b0;
        idle(5);
        rd(8'h19, 8'h02, "R6 falling line1");
        wr(8'h19, 8'hFF);
        pin_in[2] = 1'b1;
        idle(5);
        rd(8'h19, 8'h04, "R6 both rise");
        wr(8'h19, 8'hFF);
        pin_in[2] = 1'b0;
        idle(5);
        rd(8'h19, 8'h04, "R6 both fall");
        wr(8'h19, 8'hFF);
        pin_in[0] = 1'b0;
        idle(5);
        rd(8'h19, 8'h00, "R6 fall ignored on rise line");

        // R11 abandoned key, R10 full key
        wr(8'h7D, 8'h12);
        wr(8'h06, 8'h00);
        wr(8'h7D, 8'h34);
        rd(8'h0F, 8'h0F, "R11 key abandoned");
        rd(8'h7D, 8'h00, "R11 key reads zero");
        pin_in[0] = 1'b1;
        idle(5);
        wr(8'h7D, 8'h12);
        wr(8'h7D, 8'h34);
        rd(8'h0F, 8'hFF, "R10 dir restored");
        rd(8'h13, 8'hFF, "R10 mask restored");
        rd(8'h17, 8'h00, "R10 selector restored");
        rd(8'h19, 8'h00, "R10 src cleared");
        chk("R10 pin_pd", {16'h0, pin_pd}, 32'h0);
        chk("R10 irq_n", {31'h0, irq_n}, 32'h1);

        idle(2);
        finish_run();
    end
endmodule